// File: doc/BRIEF.md
# MDIO Management Bus Master

This block drives a two-wire station-management bus (MDC clock, bidirectional MDIO data) on behalf of software. Software controls it through one 32-bit word. The same word is the command on a write, and on a read it is the status and the returned data. Software writes the word with the start flag set. The block then runs one complete management frame, either Clause 22 or Clause 45, and clears the flag when the frame ends. For read opcodes it also replaces the low half of the word with the 16 bits it captured from the PHY.

A Clause 45 access takes two commands in sequence. The first is an address frame that carries the 16-bit register number in the low half. The second is a write, read or read-with-increment frame that uses the same port and device numbers. MDC is derived from the system clock by a half-period divider, and it is held low whenever no frame is running. MDIO is split into a driven value, an output enable and a sampled input, so a pad or tri-state buffer can be placed outside the block.

Top module: `mdio_master`

## Requirements
- R1: After reset `reg_rdata` is 0x4000_0000 (start flag 0, idle flag bit 30 is 1, all other fields 0), `mdc` is low and `mdio_oe` is low.
- R2: A write with bit 31 set while idle makes `reg_rdata[31]` read 1 and `reg_rdata[30]` read 0 from the next cycle. Bit 30 of any written word has no effect, and bit 30 always reads as the inverse of bit 31.
- R3: Each frame shifts out 64 bit times in this order: 32 ones, then bits 17:16 (start code), then bits 19:18 (opcode), then bits 24:20 (port), then bits 29:25 (register or device), then turnaround 1,0, then bits 15:0 MSB first. The turnaround and data are driven only for non-read frames.
- R4: A frame is a read when bits 17:16 = 01 with opcode 10, or when bits 17:16 = 00 with opcode 10 or 11. For a read, `mdio_oe` is low for bit times 46..63. The 16 values of `mdio_i` sampled in bit times 48..63 (MSB first) replace bits 15:0 when the frame completes.
- R5: `mdc` has a period of 2*HALF_DIV clocks while a frame runs, where HALF_DIV = ceil(CLK_HZ / (2*MDC_HZ)), and it stays low when idle. MDIO output changes only at MDC falling edges, and input is sampled at MDC rising edges.
- R6: Bit 31 stays 1 for exactly 128*HALF_DIV clock cycles after the starting write and clears together with the last MDC falling edge. After a non-read frame, the word reads back as written, with bits 31:30 = 01.
- R7: Any write while bit 31 reads 1 is ignored: it does not change the frame in progress or the fields read back afterwards.
- R8: A write with bit 31 clear while idle stores bits 29:0 and starts no frame (MDC stays low).
- R9: Reset clears a previously captured read value. A later read of a port that does not respond returns 0xFFFF (the pulled-up line), not an earlier value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the command/status word |
| reg_wdata | input | 32 | Word written on `reg_wr` |
| reg_rdata | output | 32 | Current command/status/data word |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Value driven onto MDIO |
| mdio_oe | output | 1 | MDIO output enable (high = master drives) |
| mdio_i | input | 1 | Sampled MDIO line |

## Verification
A fault in the bit counter or in the divider appears at the ports at once. The time that bit 31 stays high then differs from 128*HALF_DIV cycles, and the bits captured at MDC rising edges are misplaced within the same frame. A wrong read classification or turnaround enable shows within one frame, through `mdio_oe` being driven during the bit times 46 to 63. A fault in the register update only shows in `reg_rdata` after the busy flag drops. Every frame therefore ends by comparing the whole word against values the bench computes from the fields it wrote.

// File: rtl/mdio_pkg.sv
`timescale 1ns/100ps
package mdio_pkg;

    localparam int FRAME_BITS    = 64;
    localparam int PREAMBLE_BITS = 32;
    localparam int IDX_W         = $clog2(FRAME_BITS);
    localparam int TA_FIRST      = 46;
    localparam int DATA_FIRST    = 48;
    localparam int DATA_W        = 16;

    // Field order matches word bits 29:0
    typedef struct packed {
        logic [4:0]        regad;
        logic [4:0]        phyad;
        logic [1:0]        op;
        logic [1:0]        st;
        logic [DATA_W-1:0] data;
    } mdio_cmd_t;

    function automatic logic cmd_is_read(input mdio_cmd_t c);
        return (c.st == 2'b01 && c.op == 2'b10) || (c.st == 2'b00 && c.op[1]);
    endfunction

    function automatic logic [FRAME_BITS-1:0] cmd_frame(input mdio_cmd_t c);
        return {{PREAMBLE_BITS{1'b1}}, c.st, c.op, c.phyad, c.regad, 2'b10, c.data};
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
`timescale 1ns/100ps
module mdio_mdc_gen #(
    parameter int HALF_DIV = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             mdc;
    } div_t;

    div_t q, d;
    logic tick;

    always_comb begin
        d    = q;
        tick = en && (q.cnt == LAST);
        if (!en) begin
            d.cnt = '0;
            d.mdc = 1'b0;
        end else if (tick) begin
            d.cnt = '0;
            d.mdc = ~q.mdc;
        end else begin
            d.cnt = q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mdc       = q.mdc;
    assign rise_tick = tick & ~q.mdc;
    assign fall_tick = tick &  q.mdc;

    AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !q.mdc); // R5
    AST_MDC_HALF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && q.cnt != LAST) |=> $stable(q.mdc)); // R5

endmodule

// File: rtl/mdio_frame_engine.sv
`timescale 1ns/100ps
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  mdio_cmd_t         cmd,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              mdio_i,
    output logic              active,
    output logic              done,
    output logic              done_rd,
    output logic [DATA_W-1:0] rd_data,
    output logic              mdio_o,
    output logic              mdio_oe
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_FIRST);
    localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(DATA_FIRST);

    typedef struct packed {
        logic                  active;
        logic                  rd;
        logic [IDX_W-1:0]      idx;
        logic [FRAME_BITS-1:0] frame;
        logic [DATA_W-1:0]     rdsh;
        logic                  mdo;
        logic                  oe;
    } eng_t;

    eng_t q, d;
    logic [IDX_W-1:0] idx_next;
    logic             last_bit;

    always_comb begin
        d        = q;
        idx_next = q.idx + IDX_W'(1);
        last_bit = q.active && fall_tick && (q.idx == LAST_IDX);
        if (start && !q.active) begin
            d.active = 1'b1;
            d.rd     = cmd_is_read(cmd);
            d.idx    = '0;
            d.frame  = cmd_frame(cmd);
            d.mdo    = d.frame[FRAME_BITS-1];
            d.oe     = 1'b1;
            d.rdsh   = '0;
        end else if (q.active) begin
            if (rise_tick && q.rd && q.idx >= DATA_IDX)
                d.rdsh = {q.rdsh[DATA_W-2:0], mdio_i};
            if (fall_tick) begin
                if (last_bit) begin
                    d.active = 1'b0;
                    d.mdo    = 1'b0;
                    d.oe     = 1'b0;
                end else begin
                    d.idx   = idx_next;
                    d.frame = {q.frame[FRAME_BITS-2:0], 1'b0};
                    d.mdo   = q.frame[FRAME_BITS-2];
                    d.oe    = !(q.rd && idx_next >= TA_IDX);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign active  = q.active;
    assign done    = last_bit;
    assign done_rd = last_bit & q.rd;
    assign rd_data = q.rdsh;
    assign mdio_o  = q.mdo;
    assign mdio_oe = q.oe;

    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !q.active) |=> (q.active && q.idx == '0 && q.oe)); // R3
    AST_TA_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.active && q.rd && q.idx >= TA_IDX) |-> !q.oe); // R4
    AST_DRIVE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (q.active && !fall_tick) |=> $stable(q.mdo)); // R5

endmodule

// File: rtl/mdio_cmd_regs.sv
`timescale 1ns/100ps
module mdio_cmd_regs
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    input  logic              done,
    input  logic              done_rd,
    input  logic [DATA_W-1:0] rd_data,
    output logic              start,
    output mdio_cmd_t         cmd,
    output logic              busy,
    output logic [31:0]       reg_rdata
);
    typedef struct packed {
        logic      busy;
        mdio_cmd_t fields;
    } regs_t;

    regs_t q, d;
    logic  accept;
    logic  unused_idle_bit;

    assign unused_idle_bit = reg_wdata[30];

    always_comb begin
        d      = q;
        accept = reg_wr && !q.busy;
        start  = accept && reg_wdata[31];
        cmd    = mdio_cmd_t'(reg_wdata[29:0]);
        if (accept) begin
            d.fields = mdio_cmd_t'(reg_wdata[29:0]);
            d.busy   = reg_wdata[31];
        end
        if (done) begin
            d.busy = 1'b0;
            if (done_rd) d.fields.data = rd_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy      = q.busy;
    assign reg_rdata = {q.busy, ~q.busy, q.fields};

    AST_IGNORE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && reg_wr && !done) |=> $stable(q.fields)); // R7
    AST_BUSY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !q.busy); // R6

endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/100ps
module mdio_master
    import mdio_pkg::*;
#(
    parameter int CLK_HZ = 200_000_000,
    parameter int MDC_HZ = 2_500_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    localparam int HALF_DIV = (CLK_HZ + 2 * MDC_HZ - 1) / (2 * MDC_HZ);

    logic              start, busy, active, done, done_rd;
    logic              rise_tick, fall_tick;
    logic [DATA_W-1:0] rd_data;
    mdio_cmd_t         cmd;

    mdio_cmd_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .done      (done),
        .done_rd   (done_rd),
        .rd_data   (rd_data),
        .start     (start),
        .cmd       (cmd),
        .busy      (busy),
        .reg_rdata (reg_rdata)
    );

    mdio_mdc_gen #(.HALF_DIV(HALF_DIV)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (active),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cmd       (cmd),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .active    (active),
        .done      (done),
        .done_rd   (done_rd),
        .rd_data   (rd_data),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );

    AST_BUSY_TRACKS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        busy == active); // R2

endmodule

// File: tb/sim_mdio_master.sv
`timescale 1ns/100ps
module sim_mdio_master;
    localparam int CLK_HZ   = 200_000_000;
    localparam int MDC_HZ   = 50_000_000;
    localparam int HALF     = (CLK_HZ + 2 * MDC_HZ - 1) / (2 * MDC_HZ);
    localparam int BUSY_CYC = 128 * HALF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc++;

    mdio_master #(.CLK_HZ(CLK_HZ), .MDC_HZ(MDC_HZ)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY responder and line monitor
    int          rise_n = 0, fall_n = 0, per_bad = 0, last_rise = 0;
    logic [63:0] cap = '0, oe_seen = '0;
    logic        cur_rd = 1'b0;
    logic [15:0] resp = '0;

    always @(posedge mdc) begin
        if (rise_n > 0 && (cyc - last_rise) != 2 * HALF) per_bad++;
        last_rise = cyc;
        if (rise_n < 64) begin
            cap[63 - rise_n]     = mdio_o;
            oe_seen[63 - rise_n] = mdio_oe;
        end
        rise_n++;
    end

    always @(negedge mdc) begin
        fall_n++;
        if (cur_rd && fall_n == 47)                     mdio_i = 1'b0;
        else if (cur_rd && fall_n >= 48 && fall_n <= 63) mdio_i = resp[63 - fall_n];
        else                                             mdio_i = 1'b1;
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] phy_value(input logic [4:0] phy, input logic [4:0] rg);
        if (phy == 5'd31) return 16'hFFFF;
        return {phy, rg, 6'b101101} ^ 16'h3C96;
    endfunction

    task automatic run_frame(input logic [1:0] st, input logic [1:0] op,
                             input logic [4:0] phy, input logic [4:0] rg,
                             input logic [15:0] wd, input bit junk30, input bit poke);
        logic [31:0] cmd;
        logic [63:0] exp_frame, mask;
        logic [15:0] exp_data;
        bit          rd;
        int          n;
        cmd      = {1'b1, junk30, rg, phy, op, st, wd};
        rd       = (st == 2'b01 && op == 2'b10) || (st == 2'b00 && op[1]);
        resp     = phy_value(phy, rg);
        exp_data = rd ? resp : wd;
        cur_rd   = rd;
        rise_n = 0; fall_n = 0; per_bad = 0; cap = '0; oe_seen = '0;
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = cmd;
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R2", "busy/idle flags after start", 64'(reg_rdata[31:30]), 64'(2'b10));
        n = 0;
        while (reg_rdata[31] && n < 4000) begin
            n++;
            if (poke && n == 60) begin
                reg_wr = 1'b1; reg_wdata = (~cmd) | 32'h8000_0000; // R7 write during frame
            end else reg_wr = 1'b0;
            @(negedge clk);
        end
        reg_wr = 1'b0;
        chk("R6", "busy cycle count", 64'(n), 64'(BUSY_CYC));
        exp_frame = {32'hFFFF_FFFF, st, op, phy, rg, 2'b10, wd};
        mask      = rd ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
        chk(poke ? "R7" : "R3", "frame bits", cap & mask, exp_frame & mask);
        chk("R4", "drive-enable pattern", oe_seen, mask);
        chk("R5", "mdc period violations", 64'(per_bad), 64'd0);
        chk("R5", "mdc rise/fall counts", {32'(rise_n), 32'(fall_n)}, {32'd64, 32'd64});
        chk("R5", "mdc idle low, oe off", {62'b0, mdc, mdio_oe}, 64'd0);
        chk(rd ? "R4" : "R6", "word after frame", 64'(reg_rdata),
            64'({2'b01, rg, phy, op, st, exp_data}));
    endtask

    bit finished = 1'b0;

    always @(posedge clk) begin
        if (cyc > 150000 && !finished) begin
            tests++; fails++;
            $display("FAIL R6 watchdog: actual %0d cycles expected below 150000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [1:0] sts [6];
        logic [1:0] ops [6];
        sts = '{2'b01, 2'b01, 2'b00, 2'b00, 2'b00, 2'b00};
        ops = '{2'b01, 2'b10, 2'b00, 2'b01, 2'b10, 2'b11};

        repeat (4) @(negedge clk);
        chk("R1", "reset word", 64'(reg_rdata), 64'h4000_0000);
        chk("R1", "reset mdc/oe", {62'b0, mdc, mdio_oe}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "word after release", 64'(reg_rdata), 64'h4000_0000);

        for (int t = 0; t < 6; t++) begin
            for (int a = 0; a < 8; a++) begin
                logic [4:0]  phy, rg;
                logic [15:0] wd;
                phy = (a == 7) ? 5'd31 : 5'((a * 5 + t * 3) % 31);
                rg  = 5'((a * 7 + t * 11) % 32);
                wd  = 16'h1234 ^ 16'(a * 16'h1111 + t * 16'h0F0F);
                run_frame(sts[t], ops[t], phy, rg, wd, bit'(a[0]), a == 3);
            end
        end

        // R8: store without starting
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = 32'h2ABC_5678;
        @(negedge clk);
        reg_wr = 1'b0;
        rise_n = 0;
        chk("R8", "stored word", 64'(reg_rdata), 64'({2'b01, 30'h2ABC_5678}));
        repeat (30) @(negedge clk);
        chk("R8", "no mdc edges", 64'(rise_n), 64'd0);
        chk("R8", "still idle", 64'(reg_rdata[31:30]), 64'(2'b01));

        // R9: read, reset, then read an absent port
        run_frame(2'b01, 2'b10, 5'd5, 5'd2, 16'h0000, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9", "reset wipes data", 64'(reg_rdata), 64'h4000_0000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run_frame(2'b01, 2'b10, 5'd31, 5'd2, 16'h0000, 1'b0, 1'b0);
        chk("R9", "absent port data", 64'(reg_rdata[15:0]), 64'hFFFF);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule